// File: doc/BRIEF.md
# Single-Word Instruction Prefetch

This block feeds a small processor core with instructions, one 32-bit word at a time. It reads them over a read-only pipelined Wishbone master port. The core starts it by pulsing a new-PC strobe with a byte address. The block fetches that word and presents it together with its address and a valid flag. When the core takes the word by raising ready while valid is high, the block moves on to the next sequential word. While the core holds ready low, the presented word stays frozen.

A bus error does not return data. The block presents the word with a bad-instruction flag set. Once the core has taken such a word, the block stops fetching until the next new-PC strobe. A new-PC strobe or a flush drops any bus cycle in progress at once. A late acknowledge from an abandoned request has no effect. After reset or flush the block stays idle until it is given a start address.

At most one request is outstanding. There is no caching and no fetching ahead.

Top module: `insn_prefetch`

## Requirements
- R1: The bus port only reads: `wb_we_o` and `wb_dat_o` are zero at all times.
- R2: The word address on `wb_adr_o` is the fetch byte address with its two low bits removed (`wb_adr_o = pc[ADDR_W+1:2]`). `insn_pc_o` is the byte address of the presented word, and its two low bits are zero.
- R3: After reset or a flush, `wb_cyc_o` and `insn_valid_o` stay low until a new-PC strobe arrives. A flush wins over a new-PC strobe in the same cycle.
- R4: In the cycle after a new-PC strobe, `insn_valid_o` and `wb_cyc_o` are both low. In the cycle after that, the request for the new address starts with `wb_cyc_o` and `wb_stb_o` high.
- R5: A word is taken when `insn_valid_o` and `ready_i` are both high. In the next cycle `insn_valid_o` is low, `insn_pc_o` has grown by 4, and the request for that word is on the bus.
- R6: While `insn_valid_o` is high and `ready_i` is low, with no reset, flush or new-PC strobe, the outputs `insn_o`, `insn_pc_o`, `insn_valid_o` and `insn_bad_o` keep their values.
- R7: A bus error ends the fetch and presents the word with `insn_bad_o` high. `insn_bad_o` is high only while `insn_valid_o` is high. Reset, flush and new-PC strobes clear it.
- R8: At most one request is in flight. `wb_stb_o` stays high while `wb_stall_i` is high. After the request is accepted, `wb_stb_o` is low and `wb_cyc_o` stays high until an acknowledge or an error.
- R9: An acknowledge or error that arrives while `wb_cyc_o` is low is ignored.
- R10: After a word flagged bad has been taken, no request starts and `insn_valid_o` stays low until the next new-PC strobe.
- R11: `insn_o` is the bus read data captured on the acknowledge cycle, held until the word is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush_i | input | 1 | Drop all fetch state and wait for a new PC |
| new_pc_i | input | 1 | Strobe: start fetching at `pc_i` |
| pc_i | input | ADDR_W+2 | Byte address to start at (low two bits zero) |
| ready_i | input | 1 | Core takes the presented word when high |
| insn_o | output | 32 | Presented instruction word |
| insn_pc_o | output | ADDR_W+2 | Byte address of the presented word |
| insn_valid_o | output | 1 | A word is being presented |
| insn_bad_o | output | 1 | Presented word came from a bus error |
| wb_cyc_o | output | 1 | Bus cycle active |
| wb_stb_o | output | 1 | Request strobe |
| wb_we_o | output | 1 | Write enable, always 0 |
| wb_adr_o | output | ADDR_W | Word address |
| wb_dat_o | output | 32 | Write data, always 0 |
| wb_ack_i | input | 1 | Read acknowledge |
| wb_stall_i | input | 1 | Slave cannot accept the request this cycle |
| wb_err_i | input | 1 | Bus error response |
| wb_dat_i | input | 32 | Read data |

## Verification
The timing is checked against these counts:
- A new-PC strobe gives a cycle with bus and valid low.
- The request appears in the second cycle after the strobe.
- The first word is valid 3+S+L cycles after the strobe, where S is the number of slave stall cycles and L is the acknowledge latency.
- After a word is taken, the next word is valid 2+S+L cycles later.

The bench drives every input on the falling edge and samples on the falling edge. It counts falling edges from the stimulus and compares that count with the expected count for the slave latency set by each test. The same counting places the checks for:
- strobe hold and drop during slave stalls;
- the cycle line dropping one cycle after a redirect or flush;
- a stray acknowledge landing in the idle gap.

// File: rtl/insn_prefetch_pkg.sv
package insn_prefetch_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        PF_NOPC = 3'd0,   // no start address since reset/flush
        PF_ARM  = 3'd1,   // address loaded, bus idle for one cycle
        PF_REQ  = 3'd2,   // strobe high, waiting for slave to accept
        PF_WAIT = 3'd3,   // request accepted, waiting for ack/err
        PF_HOLD = 3'd4,   // word presented to the core
        PF_HALT = 3'd5    // bad word taken, parked until redirect
    } pf_state_e;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic              bad;
    } pf_slot_t;

    function automatic logic pf_on_bus(input pf_state_e s);
        return (s == PF_REQ) || (s == PF_WAIT);
    endfunction

    function automatic logic pf_response(input logic ack, input logic err);
        return ack || err;
    endfunction

endpackage

// File: rtl/pf_ctrl.sv
module pf_ctrl
    import insn_prefetch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic flush,
    input  logic redirect,
    input  logic ready,
    input  logic bus_ack,
    input  logic bus_err,
    input  logic bus_stall,
    input  logic slot_bad,
    output logic bus_cyc,
    output logic bus_stb,
    output logic present,
    output logic capture,
    output logic take
);

    pf_state_e state_q, state_d;
    logic      responded;

    assign responded = pf_response(bus_ack, bus_err);

    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = PF_NOPC;
        end else if (redirect) begin
            state_d = PF_ARM;
        end else begin
            unique case (state_q)
                PF_ARM:  state_d = PF_REQ;
                PF_REQ: begin
                    if (responded)       state_d = PF_HOLD;
                    else if (!bus_stall) state_d = PF_WAIT;
                end
                PF_WAIT: begin
                    if (responded)       state_d = PF_HOLD;
                end
                PF_HOLD: begin
                    if (ready)           state_d = slot_bad ? PF_HALT : PF_REQ;
                end
                default: state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= PF_NOPC;
        else     state_q <= state_d;
    end

    assign bus_cyc = pf_on_bus(state_q);
    assign bus_stb = (state_q == PF_REQ);
    assign present = (state_q == PF_HOLD);
    assign capture = pf_on_bus(state_q) && responded && !flush && !redirect;
    assign take    = (state_q == PF_HOLD) && ready && !flush && !redirect;

endmodule

// File: rtl/pf_addr.sv
module pf_addr #(
    parameter int ADDR_W = 30
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    output logic [ADDR_W-1:0] word_addr
);

    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    always_ff @(posedge clk) begin
        if (rst)          word_addr <= '0;
        else if (load)    word_addr <= load_addr;
        else if (advance) word_addr <= word_addr + STEP;
    end

endmodule

// File: rtl/pf_hold.sv
module pf_hold
    import insn_prefetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              drop,
    input  logic              capture,
    input  logic              take,
    input  logic              bus_err,
    input  logic [WORD_W-1:0] bus_dat,
    output pf_slot_t          slot
);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (drop || take) begin
            slot.bad <= 1'b0;
        end else if (capture) begin
            slot.word <= bus_err ? '0 : bus_dat;
            slot.bad  <= bus_err;
        end
    end

endmodule

// File: rtl/insn_prefetch.sv
module insn_prefetch
    import insn_prefetch_pkg::*;
#(
    parameter int ADDR_W = 30
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                flush_i,
    input  logic                new_pc_i,
    input  logic [ADDR_W+1:0]   pc_i,
    input  logic                ready_i,
    output logic [WORD_W-1:0]   insn_o,
    output logic [ADDR_W+1:0]   insn_pc_o,
    output logic                insn_valid_o,
    output logic                insn_bad_o,
    output logic                wb_cyc_o,
    output logic                wb_stb_o,
    output logic                wb_we_o,
    output logic [ADDR_W-1:0]   wb_adr_o,
    output logic [WORD_W-1:0]   wb_dat_o,
    input  logic                wb_ack_i,
    input  logic                wb_stall_i,
    input  logic                wb_err_i,
    input  logic [WORD_W-1:0]   wb_dat_i
);

    localparam int BYTE_SEL_W = 2;

    logic              redirect;
    logic              capture;
    logic              take;
    logic [ADDR_W-1:0] word_addr;
    pf_slot_t          slot;
    logic              unused_pc_lsb;

    assign redirect      = new_pc_i && !flush_i;
    assign unused_pc_lsb = ^pc_i[BYTE_SEL_W-1:0];

    pf_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush_i),
        .redirect  (new_pc_i),
        .ready     (ready_i),
        .bus_ack   (wb_ack_i),
        .bus_err   (wb_err_i),
        .bus_stall (wb_stall_i),
        .slot_bad  (slot.bad),
        .bus_cyc   (wb_cyc_o),
        .bus_stb   (wb_stb_o),
        .present   (insn_valid_o),
        .capture   (capture),
        .take      (take)
    );

    pf_addr #(.ADDR_W(ADDR_W)) u_addr (
        .clk       (clk),
        .rst       (rst),
        .load      (redirect),
        .load_addr (pc_i[ADDR_W+1:BYTE_SEL_W]),
        .advance   (take),
        .word_addr (word_addr)
    );

    pf_hold u_hold (
        .clk     (clk),
        .rst     (rst),
        .drop    (flush_i || new_pc_i),
        .capture (capture),
        .take    (take),
        .bus_err (wb_err_i),
        .bus_dat (wb_dat_i),
        .slot    (slot)
    );

    assign insn_o     = slot.word;
    assign insn_bad_o = slot.bad;
    assign insn_pc_o  = {word_addr, {BYTE_SEL_W{1'b0}}};
    assign wb_adr_o   = word_addr;
    assign wb_we_o    = 1'b0;
    assign wb_dat_o   = '0;

endmodule

// File: rtl/insn_prefetch_chk.sv
module insn_prefetch_chk
    import insn_prefetch_pkg::*;
#(
    parameter int ADDR_W = 30
) (
    input logic              clk,
    input logic              rst,
    input logic              flush_i,
    input logic              new_pc_i,
    input logic              ready_i,
    input logic              wb_ack_i,
    input logic              wb_err_i,
    input logic              wb_stall_i,
    input logic [WORD_W-1:0] wb_dat_i,
    input logic              wb_cyc_o,
    input logic              wb_stb_o,
    input logic              insn_valid_o,
    input logic              insn_bad_o,
    input logic [WORD_W-1:0] insn_o,
    input logic [ADDR_W+1:0] insn_pc_o
);

    // R3
    flush_idle_chk: assert property (@(posedge clk) disable iff (rst)
        flush_i |=> (!wb_cyc_o && !insn_valid_o));

    // R4
    redirect_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (new_pc_i && !flush_i) |=> (!wb_cyc_o && !insn_valid_o));

    // R5
    next_word_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_valid_o && ready_i && !insn_bad_o && !new_pc_i && !flush_i)
        |=> (wb_cyc_o && wb_stb_o && !insn_valid_o
             && insn_pc_o == $past(insn_pc_o) + (ADDR_W+2)'(4)));

    // R6
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_valid_o && !ready_i && !new_pc_i && !flush_i)
        |=> (insn_valid_o && $stable(insn_o) && $stable(insn_pc_o)
             && $stable(insn_bad_o)));

    // R7
    bad_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        insn_bad_o |-> insn_valid_o);

    // R8
    stb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_stb_o && wb_stall_i && !wb_ack_i && !wb_err_i && !new_pc_i && !flush_i)
        |=> wb_stb_o);

    // R8
    single_req_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_o && !wb_stb_o) |=> !wb_stb_o);

    // R8
    cycle_end_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_o && (wb_ack_i || wb_err_i) && !new_pc_i && !flush_i)
        |=> (!wb_cyc_o && insn_valid_o));

    // R9
    stray_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (!wb_cyc_o && !insn_valid_o && (wb_ack_i || wb_err_i)) |=> !insn_valid_o);

    // R10
    halt_after_bad_chk: assert property (@(posedge clk) disable iff (rst)
        (insn_valid_o && ready_i && insn_bad_o && !new_pc_i && !flush_i)
        |=> (!wb_cyc_o && !insn_valid_o));

    // R11
    capture_data_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_o && wb_ack_i && !wb_err_i && !new_pc_i && !flush_i)
        |=> (insn_o == $past(wb_dat_i)));

endmodule

bind insn_prefetch insn_prefetch_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .flush_i      (flush_i),
    .new_pc_i     (new_pc_i),
    .ready_i      (ready_i),
    .wb_ack_i     (wb_ack_i),
    .wb_err_i     (wb_err_i),
    .wb_stall_i   (wb_stall_i),
    .wb_dat_i     (wb_dat_i),
    .wb_cyc_o     (wb_cyc_o),
    .wb_stb_o     (wb_stb_o),
    .insn_valid_o (insn_valid_o),
    .insn_bad_o   (insn_bad_o),
    .insn_o       (insn_o),
    .insn_pc_o    (insn_pc_o)
);

// File: tb/insn_prefetch_tb.sv
`timescale 1ns/1ps
module insn_prefetch_tb;

    localparam int AW = 30;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1, flush_i = 1'b0, new_pc_i = 1'b0, ready_i = 1'b0;
    logic [AW+1:0] pc_i = '0;
    logic          wb_ack_i, wb_stall_i, wb_err_i;
    logic [31:0]   wb_dat_i;
    logic [31:0]   insn_o, wb_dat_o;
    logic [AW+1:0] insn_pc_o;
    logic          insn_valid_o, insn_bad_o, wb_cyc_o, wb_stb_o, wb_we_o;
    logic [AW-1:0] wb_adr_o;

    insn_prefetch #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst), .flush_i(flush_i), .new_pc_i(new_pc_i), .pc_i(pc_i),
        .ready_i(ready_i), .insn_o(insn_o), .insn_pc_o(insn_pc_o),
        .insn_valid_o(insn_valid_o), .insn_bad_o(insn_bad_o),
        .wb_cyc_o(wb_cyc_o), .wb_stb_o(wb_stb_o), .wb_we_o(wb_we_o),
        .wb_adr_o(wb_adr_o), .wb_dat_o(wb_dat_o), .wb_ack_i(wb_ack_i),
        .wb_stall_i(wb_stall_i), .wb_err_i(wb_err_i), .wb_dat_i(wb_dat_i)
    );

    // ---------------- bus slave model ----------------
    int            cfg_stall = 0, cfg_lat = 0;
    bit            err_en = 1'b0;
    logic [AW-1:0] err_adr = '0;
    bit            s_fresh = 1'b1, s_acc = 1'b0, s_done = 1'b0;
    int            s_cnt = 0, l_cnt = 0;
    logic          slv_ack = 1'b0, slv_err = 1'b0, slv_stall = 1'b0, man_ack = 1'b0;
    logic [31:0]   slv_dat = '0;

    assign wb_ack_i   = slv_ack | man_ack;
    assign wb_err_i   = slv_err;
    assign wb_stall_i = slv_stall;
    assign wb_dat_i   = slv_dat;

    function automatic logic [31:0] mem(input logic [AW-1:0] a);
        return (32'(a) * 32'h0100_0193) ^ 32'h3C5A_0F11;
    endfunction

    task automatic slv_respond();
        s_done = 1'b1;
        if (err_en && wb_adr_o == err_adr) slv_err = 1'b1;
        else begin
            slv_ack = 1'b1;
            slv_dat = mem(wb_adr_o);
        end
    endtask

    always @(negedge clk) begin
        slv_ack = 1'b0;
        slv_err = 1'b0;
        if (!wb_cyc_o) begin
            s_fresh = 1'b1; s_acc = 1'b0; s_done = 1'b0; slv_stall = 1'b0;
        end else if (!s_done) begin
            if (s_fresh) begin
                s_cnt = cfg_stall;
                s_fresh = 1'b0;
            end
            if (wb_stb_o && !s_acc) begin
                if (s_cnt > 0) begin
                    slv_stall = 1'b1;
                    s_cnt--;
                end else begin
                    slv_stall = 1'b0;
                    s_acc = 1'b1;
                    l_cnt = cfg_lat;
                    if (l_cnt == 0) slv_respond();
                end
            end else if (s_acc) begin
                if (l_cnt > 1) l_cnt--;
                else slv_respond();
            end
        end
    end

    // ---------------- check bookkeeping ----------------
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    // new-PC strobe; returns after the first cycle (k = 1)
    task automatic redirect(input logic [AW+1:0] pc);
        new_pc_i = 1'b1;
        pc_i     = pc;
        tick();
        new_pc_i = 1'b0;
        chk(!insn_valid_o && !wb_cyc_o, "R4", "valid/cyc after new pc",
            {insn_valid_o, wb_cyc_o}, 0);
        chk(!insn_bad_o, "R7", "bad cleared by new pc", insn_bad_o, 0);
    endtask

    task automatic take();
        ready_i = 1'b1;
        tick();
        ready_i = 1'b0;
    endtask

    task automatic run_to_valid(input int k0, output int k);
        k = k0;
        while (!insn_valid_o && k < 64) begin
            tick();
            k++;
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        bit quiet = 1'b1;
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        chk(!insn_valid_o && !wb_cyc_o && !wb_stb_o && !insn_bad_o, "R3",
            "reset state", {insn_valid_o, wb_cyc_o, wb_stb_o, insn_bad_o}, 0);
        chk(wb_we_o == 1'b0 && wb_dat_o == '0, "R1", "write lines idle",
            {wb_we_o, wb_dat_o}, 0);
        for (int i = 0; i < 8; i++) begin
            tick();
            if (wb_cyc_o || insn_valid_o) quiet = 1'b0;
        end
        chk(quiet, "R3", "no fetch without pc", quiet, 1);
    endtask

    task automatic t_first();
        int k;
        cfg_stall = 0; cfg_lat = 0;
        redirect(34'h100);
        tick();
        chk(wb_cyc_o && wb_stb_o, "R4", "request starts 2nd cycle",
            {wb_cyc_o, wb_stb_o}, 2'b11);
        chk(wb_adr_o == 30'h40, "R2", "word address", wb_adr_o, 30'h40);
        run_to_valid(2, k);
        chk(k == 3, "R4", "first valid cycle", k, 3);
        chk(insn_o == mem(30'h40), "R11", "first word", insn_o, mem(30'h40));
        chk(insn_pc_o == 34'h100, "R2", "presented pc", insn_pc_o, 34'h100);
        chk(!insn_bad_o, "R7", "good word not bad", insn_bad_o, 0);
    endtask

    task automatic t_stream();
        int k, s, l;
        logic [AW+1:0] exp_pc;
        for (int i = 0; i < 6; i++) begin
            s = i % 3;
            l = (i * 2) % 3;
            cfg_stall = s; cfg_lat = l;
            exp_pc = insn_pc_o + 34'd4;
            take();
            chk(insn_pc_o == exp_pc && !insn_valid_o && wb_cyc_o, "R5",
                "advance after take", insn_pc_o, exp_pc);
            chk(wb_we_o == 1'b0 && wb_dat_o == '0, "R1", "read only in cycle",
                {wb_we_o, wb_dat_o}, 0);
            run_to_valid(1, k);
            chk(k == 2 + s + l, "R5", "next valid cycle", k, 2 + s + l);
            chk(insn_o == mem(exp_pc[AW+1:2]), "R11", "stream word",
                insn_o, mem(exp_pc[AW+1:2]));
        end
    endtask

    task automatic t_hold();
        logic [31:0]   w = insn_o;
        logic [AW+1:0] p = insn_pc_o;
        ready_i = 1'b0;
        for (int i = 0; i < 6; i++) begin
            tick();
            chk(insn_valid_o && insn_o == w && insn_pc_o == p && !insn_bad_o,
                "R6", "hold while not ready", insn_o, w);
        end
    endtask

    task automatic t_busstall();
        int k;
        logic [AW+1:0] exp_pc;
        cfg_stall = 3; cfg_lat = 2;
        exp_pc = insn_pc_o + 34'd4;
        take();
        for (k = 1; k <= 6; k++) begin
            chk(wb_cyc_o && (wb_stb_o == (k <= 4)), "R8", "strobe during stall",
                {wb_cyc_o, wb_stb_o}, {1'b1, (k <= 4)});
            tick();
        end
        chk(insn_valid_o && !wb_cyc_o, "R8", "cycle ends on ack",
            {insn_valid_o, wb_cyc_o}, 2'b10);
        chk(insn_o == mem(exp_pc[AW+1:2]), "R11", "stalled fetch data",
            insn_o, mem(exp_pc[AW+1:2]));
    endtask

    task automatic t_stale();
        int k;
        cfg_stall = 0; cfg_lat = 6;
        redirect(34'h200);
        tick();
        tick();
        chk(wb_cyc_o && !wb_stb_o, "R8", "waiting for ack", {wb_cyc_o, wb_stb_o}, 2'b10);
        new_pc_i = 1'b1;
        pc_i = 34'h300;
        tick();
        new_pc_i = 1'b0;
        chk(!wb_cyc_o && !insn_valid_o, "R4", "cycle abandoned",
            {wb_cyc_o, insn_valid_o}, 0);
        man_ack = 1'b1;
        tick();
        man_ack = 1'b0;
        chk(!insn_valid_o, "R9", "stray ack ignored", insn_valid_o, 0);
        chk(wb_cyc_o && wb_stb_o && wb_adr_o == 30'hC0, "R2", "new request address",
            wb_adr_o, 30'hC0);
        run_to_valid(2, k);
        chk(k == 9, "R9", "valid timed by real ack", k, 9);
        chk(insn_pc_o == 34'h300 && insn_o == mem(30'hC0), "R9", "redirected word",
            insn_o, mem(30'hC0));
    endtask

    task automatic t_newpc_hold();
        int k;
        cfg_stall = 0; cfg_lat = 0;
        ready_i = 1'b0;
        chk(insn_valid_o, "R4", "word held before redirect", insn_valid_o, 1);
        redirect(34'h80);
        run_to_valid(1, k);
        chk(k == 3 && insn_o == mem(30'h20), "R4", "fetch after redirect", k, 3);
    endtask

    task automatic t_error();
        int k;
        bit quiet = 1'b1;
        cfg_stall = 0; cfg_lat = 1;
        err_en = 1'b1; err_adr = 30'h80;
        redirect(34'h200);
        run_to_valid(1, k);
        chk(k == 4, "R7", "error response cycle", k, 4);
        chk(insn_bad_o && insn_valid_o, "R7", "bad flag with valid",
            {insn_bad_o, insn_valid_o}, 2'b11);
        take();
        for (int i = 0; i < 10; i++) begin
            if (wb_cyc_o || insn_valid_o || insn_bad_o) quiet = 1'b0;
            tick();
        end
        chk(quiet, "R10", "halted after bad taken", quiet, 1);
        redirect(34'h200);
        run_to_valid(1, k);
        chk(insn_bad_o, "R7", "second error word", insn_bad_o, 1);
        err_en = 1'b0;
        redirect(34'h400);
        run_to_valid(1, k);
        chk(!insn_bad_o && insn_o == mem(30'h100), "R7", "recovered after redirect",
            insn_o, mem(30'h100));
    endtask

    task automatic t_flush();
        int k;
        bit quiet = 1'b1;
        cfg_stall = 0; cfg_lat = 5;
        take();
        tick();
        flush_i = 1'b1;
        new_pc_i = 1'b1;
        pc_i = 34'h40;
        tick();
        flush_i = 1'b0;
        new_pc_i = 1'b0;
        chk(!wb_cyc_o && !insn_valid_o, "R3", "flush drops cycle",
            {wb_cyc_o, insn_valid_o}, 0);
        for (int i = 0; i < 10; i++) begin
            tick();
            if (wb_cyc_o || insn_valid_o) quiet = 1'b0;
        end
        chk(quiet, "R3", "idle after flush", quiet, 1);
        redirect(34'h40);
        run_to_valid(1, k);
        chk(k == 8 && insn_o == mem(30'h10), "R3", "restart after flush", k, 8);
    endtask

    task automatic t_rst_mid();
        bit quiet = 1'b1;
        cfg_stall = 0; cfg_lat = 4;
        take();
        tick();
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk(!wb_cyc_o && !insn_valid_o && !insn_bad_o, "R3", "reset mid cycle",
            {wb_cyc_o, insn_valid_o, insn_bad_o}, 0);
        for (int i = 0; i < 6; i++) begin
            tick();
            if (wb_cyc_o) quiet = 1'b0;
        end
        chk(quiet, "R3", "idle after reset", quiet, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_first();
        t_stream();
        t_hold();
        t_busstall();
        t_stale();
        t_newpc_hold();
        t_error();
        t_flush();
        t_rst_mid();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule